// File: doc/BRIEF.md
# Program RAM Download Port

This block gives a host a single 32-bit register through which it fills the program memory of an embedded microcontroller and then reads that memory back for verification. A register write carries three fields: a control byte in bits 31:24, a data byte in bits 23:16 and a byte address in bits 13:0. Writing the control code 0x0F places the block in upload mode. In that mode the microcontroller is held in reset and the data byte is committed to program RAM at the given address. Any other control code releases the microcontroller and leaves the RAM alone.

A register read returns the control byte, the RAM byte at the current address, and that address. The read then advances the address. A host can therefore verify a whole image with one positioning write followed by back-to-back reads. It can also drain reads until the address field wraps to zero.

A RAM write lands a fixed number of clocks after the register write. This models the settling time the host has to wait before a readback is meaningful.

Top module: `prd_dl_port`

## Requirements
- R1: After reset, the read data output is 0x00000000, the microcontroller reset output is low and the address counter is 0.
- R2: A register write replaces the stored control byte with write bits 31:24. Every later read returns that byte in read bits 31:24.
- R3: From the clock after a write, the microcontroller reset output is high if the written control byte is 0x0F and low for any other value.
- R4: A write with control byte 0x0F stores data bits 23:16 at the address in bits 13:0, and bits 15:14 of the write are ignored. A write with any other control byte leaves program RAM unchanged.
- R5: A write loads the address counter with write bits 13:0, so the next read reports that address and the byte stored there.
- R6: A read presents {control, RAM byte, 2'b00, address} on the read data output one clock after the read strobe. The address counter then increments by one.
- R7: The address counter is 14 bits wide and wraps from 16383 to 0 on a read.
- R8: A stored byte becomes visible to a read strobed WR_LAT+1 or more clocks after its write. A read strobed earlier returns the previous content of that location.
- R9: Addresses at or above RAM_DEPTH hold no storage. Writes to them are discarded, and reads of them return data byte 0x00 while the address still increments.
- R10: When read and write strobes coincide, the write takes effect and the read is ignored: the read data output keeps its value and the counter takes the written address.
- R11: The read data output holds its value in every clock without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write word: control[31:24], data[23:16], address[13:0] |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Read word: control[31:24], RAM byte[23:16], 2'b00, address[13:0] |
| mcu_rst_o | output | 1 | Microcontroller reset, high while upload mode is selected |

## Verification
On every clock the assertions check the following: the microcontroller reset follows the last written control code, the read data output holds when no read is accepted, back-to-back reads report consecutive addresses modulo 16384, and a read right after a write reports the written address. Only the bench scenarios can show the RAM contents. These include the latency window before a written byte becomes readable, discarded writes outside upload mode or beyond the RAM depth, and readback of a full image after positioning. For these the bench compares against a behavioural model with a queue of pending commits.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int REG_W      = 32;
  localparam int CTRL_W     = 8;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 14;
  localparam int CTRL_LSB   = 24;
  localparam int BYTE_LSB   = 16;
  localparam logic [CTRL_W-1:0] UPLOAD_CODE = 8'h0F;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [BYTE_W-1:0] data;
    logic [1:0]        pad;
    logic [ADDR_W-1:0] addr;
  } dl_word_t;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/prd_ctrl_reg.sv
module prd_ctrl_reg
  import prd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              mcu_rst_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      hold_q <= 1'b0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_i;
      hold_q <= (ctrl_i == UPLOAD_CODE);
    end
  end

  assign ctrl_o    = ctrl_q;
  assign mcu_rst_o = hold_q;
endmodule

// File: rtl/prd_addr_ctr.sv
module prd_addr_ctr
  import prd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  // load wins over step; natural 14-bit wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_addr_i;
    else if (step_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/prd_wr_pipe.sv
module prd_wr_pipe
  import prd_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_req_t req_i,
  output wr_req_t req_o
);
  wr_req_t stage_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= req_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign req_o = stage_q[LAT-1];
endmodule

// File: rtl/prd_ram.sv
module prd_ram
  import prd_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_req_t           wr_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_byte_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rd_q;
  logic              wr_hit;
  logic              rd_hit;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;

  always_comb begin
    wr_hit = wr_i.vld && (int'(wr_i.addr) < DEPTH);
    rd_hit = int'(rd_addr_i) < DEPTH;
    wr_idx = wr_i.addr[IDX_W-1:0];
    rd_idx = rd_addr_i[IDX_W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (wr_hit) mem[wr_idx] <= wr_i.data;
  end

  // read-before-write: a same-edge commit is not yet visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_hit ? mem[rd_idx] : '0;
  end

  assign rd_byte_o = rd_q;
endmodule

// File: rtl/prd_dl_port.sv
module prd_dl_port
  import prd_pkg::*;
#(
  parameter int RAM_DEPTH = 2048,
  parameter int WR_LAT    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             mcu_rst_o
);
  dl_word_t          wr_word;
  logic [CTRL_W-1:0] ctrl;
  logic [ADDR_W-1:0] addr;
  logic              rd_take;
  wr_req_t           req_in;
  wr_req_t           req_commit;
  logic [BYTE_W-1:0] rd_byte;
  logic [CTRL_W-1:0] rd_ctrl_q;
  logic [ADDR_W-1:0] rd_addr_q;

  assign wr_word = dl_word_t'(wr_data_i);
  assign rd_take = rd_en_i && !wr_en_i;

  always_comb begin
    req_in.vld  = wr_en_i && (wr_word.ctrl == UPLOAD_CODE);
    req_in.addr = wr_word.addr;
    req_in.data = wr_word.data;
  end

  prd_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .ctrl_i    (wr_word.ctrl),
    .ctrl_o    (ctrl),
    .mcu_rst_o (mcu_rst_o)
  );

  prd_addr_ctr u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (wr_en_i),
    .load_addr_i (wr_word.addr),
    .step_i      (rd_take),
    .addr_o      (addr)
  );

  prd_wr_pipe #(.LAT(WR_LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_in),
    .req_o  (req_commit)
  );

  prd_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (req_commit),
    .rd_en_i   (rd_take),
    .rd_addr_i (addr),
    .rd_byte_o (rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ctrl_q <= '0;
      rd_addr_q <= '0;
    end else if (rd_take) begin
      rd_ctrl_q <= ctrl;
      rd_addr_q <= addr;
    end
  end

  assign rd_data_o = {rd_ctrl_q, rd_byte, 2'b00, rd_addr_q};
endmodule

// File: rtl/prd_dl_port_chk.sv
module prd_dl_port_chk
  import prd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             rd_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             mcu_rst_o
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (rd_data_o == '0 && !mcu_rst_o);
    end
  end

  // R3
  upload_holds_mcu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] == UPLOAD_CODE |=> mcu_rst_o);

  // R3
  other_releases_mcu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[31:24] != UPLOAD_CODE |=> !mcu_rst_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R10
  collide_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && wr_en_i |=> $stable(rd_data_o));

  // R6
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> rd_data_o[15:14] == 2'b00);

  // R7
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i && $past(rd_en_i && !wr_en_i && rst_ni)
    |=> rd_data_o[13:0] == $past(rd_data_o[13:0]) + 14'd1);

  // R5
  load_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i && $past(wr_en_i && rst_ni)
    |=> rd_data_o[13:0] == $past(wr_data_i[13:0], 2));
endmodule

bind prd_dl_port prd_dl_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .mcu_rst_o (mcu_rst_o)
);

// File: tb/test_prd_dl_port.sv
`timescale 1ns/1ps
module test_prd_dl_port;
  localparam int DEPTH = 2048;
  localparam int LAT   = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        mcu_rst_o;

  always #5 clk = ~clk;

  prd_dl_port #(.RAM_DEPTH(DEPTH), .WR_LAT(LAT)) i_prd_dl_port (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .mcu_rst_o(mcu_rst_o)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string cur_req = "R1";

  // reference model
  byte unsigned mem [int];
  int           due_q [$];
  int           pa_q  [$];
  byte unsigned pd_q  [$];
  int           cyc = 0;
  byte unsigned m_ctrl = 0;
  int           m_addr = 0;
  bit           m_mcu  = 0;
  logic [31:0]  m_rd   = '0;
  bit           m_known = 1;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp, logic [31:0] mask);
    tests++;
    if ((got & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(bit wr, logic [31:0] wd, bit rd);
    wr_en_i = wr; wr_data_i = wd; rd_en_i = rd;
    @(posedge clk);
    cyc++;
    if (rd && !wr) begin
      byte unsigned b;
      m_known = 1;
      if (m_addr >= DEPTH) b = 0;
      else if (mem.exists(m_addr)) b = mem[m_addr];
      else begin b = 0; m_known = 0; end
      m_rd = {m_ctrl, b, 2'b00, 14'(m_addr)};
    end
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      if (pa_q[0] < DEPTH) mem[pa_q[0]] = pd_q[0];
      void'(due_q.pop_front()); void'(pa_q.pop_front()); void'(pd_q.pop_front());
    end
    if (wr) begin
      m_ctrl = wd[31:24];
      m_addr = int'(wd[13:0]);
      m_mcu  = (wd[31:24] == 8'h0F);
      if (wd[31:24] == 8'h0F) begin
        due_q.push_back(cyc + LAT); pa_q.push_back(int'(wd[13:0])); pd_q.push_back(wd[23:16]);
      end
    end else if (rd) begin
      m_addr = (m_addr + 1) % 16384;
    end
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    check(cur_req, rd_data_o, m_rd, m_known ? 32'hFFFF_FFFF : 32'hFF00_FFFF);
    check(cur_req, {31'b0, mcu_rst_o}, {31'b0, m_mcu}, 32'h1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0);
  endtask

  function automatic logic [31:0] word(byte unsigned c, byte unsigned d, int a);
    return {c, d, 2'b00, 14'(a)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", rd_data_o, 32'h0, 32'hFFFF_FFFF);
    check("R1", {31'b0, mcu_rst_o}, 32'h0, 32'h1);
    rst_ni = 1'b1;
    @(negedge clk);
    cur_req = "R1"; step(0, '0, 1);
    check("R1", rd_data_o[13:0], 32'h0, 32'h3FFF);

    // R3, R4: upload image, bits 15:14 set on odd addresses
    cur_req = "R4";
    for (int a = 0; a < 8; a++) step(1, word(8'h0F, 8'(8'hA0 + a), a) | ((a % 2) ? 32'h0000_C000 : 0), 0);
    check("R3", {31'b0, mcu_rst_o}, 32'h1, 32'h1);
    idle(LAT + 1);

    // R5, R6: position and read back
    cur_req = "R5"; step(1, word(8'h0F, 8'hA0, 0), 0); idle(LAT + 1);
    cur_req = "R6";
    for (int a = 0; a < 8; a++) step(0, '0, 1);
    check("R6", rd_data_o, word(8'h0F, 8'hA7, 7), 32'hFFFF_FFFF);

    // R8: latency window
    cur_req = "R8";
    for (int d = 1; d <= LAT + 2; d++) begin
      step(1, word(8'h0F, 8'(8'h10 + d), 100 + d), 0);
      idle(d - 1);
      step(0, '0, 1);
    end

    // R2, R3, R4: non-upload write leaves RAM, releases MCU
    cur_req = "R2"; step(1, word(8'h3C, 8'hEE, 3), 0);
    check("R3", {31'b0, mcu_rst_o}, 32'h0, 32'h1);
    idle(LAT + 1);
    cur_req = "R4"; step(0, '0, 1);
    check("R4", rd_data_o, word(8'h3C, 8'hA3, 3), 32'hFFFF_FFFF);

    // R9: beyond depth
    cur_req = "R9"; step(1, word(8'h0F, 8'h55, 3000), 0); idle(LAT + 1);
    step(0, '0, 1);
    check("R9", rd_data_o, word(8'h0F, 8'h00, 3000), 32'hFFFF_FFFF);

    // R7: wrap
    cur_req = "R7"; step(1, word(8'h0F, 8'h66, 16382), 0);
    for (int i = 0; i < 3; i++) step(0, '0, 1);
    check("R7", rd_data_o[13:0], 32'h0, 32'h3FFF);

    // R10: collision
    cur_req = "R10"; step(0, '0, 1);
    step(1, word(8'h0F, 8'h77, 5), 1);
    step(0, '0, 1);
    check("R10", rd_data_o[13:0], 32'd5, 32'h3FFF);

    // R11: idle hold, then mixed traffic
    cur_req = "R11"; idle(5);
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 3) step(1, word((r == 0) ? 8'h01 : 8'h0F, 8'($urandom), $urandom_range(0, 40)), $urandom_range(0, 1));
      else if (r < 7) step(0, '0, 1);
      else step(0, '0, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule